// File: doc/BRIEF.md
# Serial ADC Conversion Readout Controller

This block is the host side of a three-wire link to a serial analog-to-digital converter. It drives a serial clock and a convert strobe toward the converter and takes in a single serial data line. When the block is idle, a start request makes it raise the convert strobe for one period of the serial clock. It then runs a fixed frame of serial clock periods and collects a reference-ready status bit and a 12-bit sample, most significant bit first.

The serial clock is derived from the system clock. A parameter sets its half period in system cycles. The converter changes its data after each rising serial clock edge. The controller therefore takes each bit at the system cycle in which it drives that rising edge, before the converter can update the line. When the converter is slow to set up after the convert strobe, its output arrives one serial clock later. An alignment input, latched when a frame starts, moves every capture point back by one edge to match. At the end of the frame the sample and the status flag update, together with a one-cycle done pulse.

Top module: `adc_serial_reader`

## Requirements
- R1: While reset is high and in the cycle after it, sclk_o, conv_o, busy_o, done_o, refrdy_o and sample_o are all zero.
- R2: A start_i seen high while idle sets busy_o and conv_o high in the next cycle. conv_o then stays high for exactly 2*HALF system cycles, and sclk_o stays low during that time.
- R3: start_i has no effect while busy_o is high. The frame that is running keeps its length, and conv_o does not rise again until the frame has ended.
- R4: Directly after conv_o falls, sclk_o runs exactly 15 periods. Each period is HALF cycles low followed by HALF cycles high. Rising edges are numbered 1 to 15 from the first one after the convert strobe.
- R5: With normal alignment (align_late_i low at start), sdi_i is captured in the cycle that drives rising edge 2 as the reference-ready flag. Edges 3 to 14 capture data bits 11 down to 0.
- R6: With late alignment (align_late_i high at start), every capture point moves one edge later. The flag is taken at edge 3 and bits 11 down to 0 at edges 4 to 15.
- R7: align_late_i is sampled only when a start is accepted. A change of align_late_i during a frame leaves that frame's result unchanged.
- R8: One cycle after the last serial clock period ends, done_o is high for a single cycle and busy_o is low. sample_o and refrdy_o show the new result in that same cycle and hold it until the next done_o.
- R9: conv_o and sclk_o are never high in the same cycle, and neither is high while busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request, taken only when idle |
| align_late_i | input | 1 | Selects the one-edge-later capture alignment |
| sdi_i | input | 1 | Serial data from the converter |
| sclk_o | output | 1 | Generated serial clock |
| conv_o | output | 1 | Convert strobe |
| busy_o | output | 1 | High from accepted start until frame end |
| done_o | output | 1 | One-cycle result-valid pulse |
| sample_o | output | 12 | Last captured conversion result |
| refrdy_o | output | 1 | Last captured reference-ready flag |

## Verification
A wrong divider or phase count shows up on sclk_o or conv_o within one serial clock period, because the bench models both lines cycle by cycle. A wrong edge counter or a wrong capture window cannot be seen until the end of the frame. It then appears as a wrong sample_o or refrdy_o, or as done_o in the wrong cycle. The test words put different values on neighbouring bits and flip the bit value around the edges of the window, so a capture point that is off by one edge corrupts the result. A mid-frame change of the alignment input shows whether the alignment was latched at start.

// File: rtl/adc_serial_reader.sv
module adc_serial_reader #(
  parameter int HALF   = 2,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              align_late_i,
  input  logic              sdi_i,
  output logic              sclk_o,
  output logic              conv_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] sample_o,
  output logic              refrdy_o
);
  localparam int PER    = 2 * HALF;
  localparam int DW     = (PER > 2) ? $clog2(PER) : 1;
  localparam int EDGES  = DATA_W + 3;
  localparam int EW     = $clog2(EDGES + 1);

  typedef enum logic [1:0] {S_IDLE, S_CONV, S_SHIFT} state_t;

  state_t            state;
  logic [DW-1:0]     div_cnt;
  logic [EW-1:0]     edge_cnt;
  logic [DATA_W:0]   shreg;
  logic              late_q;

  logic              per_end, rise_now;
  logic [EW-1:0]     nxt_edge, cap_lo, cap_hi;

  assign per_end  = (div_cnt == DW'(PER - 1));
  assign rise_now = (state == S_SHIFT) && (div_cnt == DW'(HALF - 1));
  assign nxt_edge = edge_cnt + 1'b1;
  assign cap_lo   = late_q ? EW'(3) : EW'(2);
  assign cap_hi   = cap_lo + EW'(DATA_W);
  assign busy_o   = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      div_cnt  <= '0;
      edge_cnt <= '0;
      shreg    <= '0;
      late_q   <= 1'b0;
      sclk_o   <= 1'b0;
      conv_o   <= 1'b0;
      done_o   <= 1'b0;
      sample_o <= '0;
      refrdy_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start_i) begin
            state   <= S_CONV;
            conv_o  <= 1'b1;
            late_q  <= align_late_i;
            div_cnt <= '0;
          end
        end
        S_CONV: begin
          if (per_end) begin
            state    <= S_SHIFT;
            conv_o   <= 1'b0;
            div_cnt  <= '0;
            edge_cnt <= '0;
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        S_SHIFT: begin
          if (per_end) begin
            div_cnt <= '0;
            sclk_o  <= 1'b0;
            if (edge_cnt == EW'(EDGES)) begin
              state    <= S_IDLE;
              done_o   <= 1'b1;
              sample_o <= shreg[DATA_W-1:0];
              refrdy_o <= shreg[DATA_W];
            end
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
          if (rise_now) begin
            sclk_o   <= 1'b1;
            edge_cnt <= nxt_edge;
            if (nxt_edge >= cap_lo && nxt_edge <= cap_hi)
              shreg <= {shreg[DATA_W-1:0], sdi_i};
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_serial_reader_chk.sv
module adc_serial_reader_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              sclk_o,
  input logic              conv_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [DATA_W-1:0] sample_o,
  input logic              refrdy_o
);
  p_lines_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    !(conv_o && sclk_o));
  p_lines_need_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (conv_o || sclk_o) |-> busy_o);
  p_conv_from_idle_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(conv_o) |-> $past(!busy_o));
  p_conv_then_clock_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(conv_o) |-> !sclk_o && busy_o);
  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  p_done_ends_frame_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o && $past(busy_o));
  p_result_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(sample_o) && $stable(refrdy_o));
endmodule

bind adc_serial_reader adc_serial_reader_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .sclk_o(sclk_o), .conv_o(conv_o), .busy_o(busy_o),
  .done_o(done_o), .sample_o(sample_o), .refrdy_o(refrdy_o)
);

// File: tb/adc_serial_reader_tb.sv
module adc_serial_reader_tb_top;
  localparam int HALF = 2;
  localparam int DW   = 12;
  localparam int CONV_END = 2 * HALF;
  localparam int BUSY_END = 32 * HALF;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, late = 1'b0, sdi = 1'b0;
  logic sclk, conv, busy, done, refrdy;
  logic [DW-1:0] sample;

  adc_serial_reader #(.HALF(HALF), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .align_late_i(late), .sdi_i(sdi),
    .sclk_o(sclk), .conv_o(conv), .busy_o(busy), .done_o(done),
    .sample_o(sample), .refrdy_o(refrdy)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int tk = 0;
  logic m_late = 1'b0;
  logic [DW-1:0] word = '0, m_word = '0, e_sample = '0;
  logic ref_bit = 1'b0, m_ref = 1'b0, e_ref = 1'b0;
  logic e_conv = 0, e_sclk = 0, e_busy = 0, e_done = 0;
  string dtag = "R5";

  always @(posedge clk) begin
    if (rst) begin
      tk = 0; e_sample = '0; e_ref = 1'b0;
    end else begin
      if (tk == 0 || tk == BUSY_END + 1) begin
        if (start) begin tk = 1; m_late = late; m_word = word; m_ref = ref_bit; end
        else tk = 0;
      end else tk++;
      if (tk == BUSY_END + 1) begin e_sample = m_word; e_ref = m_ref; end
    end
    e_busy = (tk >= 1 && tk <= BUSY_END);
    e_conv = (tk >= 1 && tk <= CONV_END);
    e_sclk = (tk > CONV_END && tk <= BUSY_END) && (((tk - CONV_END - 1) % (2*HALF)) >= HALF);
    e_done = (tk == BUSY_END + 1);
  end

  // behavioural converter: drives bit for the next rising edge
  int k = 0;
  logic p_sclk = 0, p_conv = 0;
  function automatic logic bit_for(int e);
    int off = m_late ? 3 : 2;
    if (e == off) return m_ref;
    if (e > off && e <= off + DW) return m_word[off + DW - e];
    return ~e[0];
  endfunction

  task automatic chk(string rq, string nm, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", rq, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (conv && !p_conv) k = 0;
    if (sclk && !p_sclk) k++;
    p_sclk = sclk; p_conv = conv;
    sdi = bit_for(k + 1);
    if (!rst) begin
      chk("R2", "conv", conv, e_conv);
      chk("R4", "sclk", sclk, e_sclk);
      chk("R3", "busy", busy, e_busy);
      chk("R8", "done", done, e_done);
      chk(dtag, "sample", sample, e_sample);
      chk(dtag, "refrdy", refrdy, e_ref);
      chk("R9", "excl", int'(conv && sclk), 0);
    end
  end

  task automatic run_frame(logic [DW-1:0] w, logic r, logic lt, bit hold_start, bit flip_mid);
    word = w; ref_bit = r; late = lt;
    @(negedge clk); start = 1'b1;
    @(negedge clk); if (!hold_start) start = 1'b0;
    if (flip_mid) begin repeat (10 * HALF) @(negedge clk); late = ~late; end
    while (busy) @(negedge clk);
    start = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset_outs", {sclk, conv, busy, done, refrdy, sample}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "after_reset", {sclk, conv, busy, done, refrdy, sample}, 0);
    dtag = "R5"; run_frame(12'hA5C, 1'b1, 1'b0, 0, 0);
    dtag = "R5"; run_frame(12'h001, 1'b0, 1'b0, 0, 0);
    dtag = "R6"; run_frame(12'h3F0, 1'b0, 1'b1, 0, 0);
    dtag = "R6"; run_frame(12'h800, 1'b1, 1'b1, 0, 0);
    dtag = "R3"; run_frame(12'hFFF, 1'b1, 1'b0, 1, 0);
    dtag = "R7"; run_frame(12'h6B9, 1'b1, 1'b0, 0, 1);
    dtag = "R7"; run_frame(12'h9C3, 1'b0, 1'b1, 0, 1);
    dtag = "R8"; run_frame(12'h000, 1'b0, 1'b0, 0, 0);
    repeat (5) @(negedge clk);
    chk("R8", "hold_after_done", sample, 12'h000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule